// File: doc/BRIEF.md
# Virtual Port Window Redirector

This block lets a CPU reach the DIR, OUT and IN registers of up to eight general-purpose I/O ports through a short, fixed address window. The window holds four virtual ports. For each one, a runtime field picks which physical port it stands for. An access to a virtual register is sent on to the same register of the chosen physical port. Read data comes back unchanged. Software can therefore retarget a short, cheap address to any port without changing its access code.

A second request channel reaches the physical ports by their own addresses and works alongside the virtual path. The port register banks sit outside the block. The block drives one write strobe and one data byte per port and per writable register. It reads each bank's current DIR, OUT and IN values from flat input vectors.

Both request channels use valid/ready. A request is taken in a cycle where valid and ready are both high. Writes produce no response. A read produces one response beat, which stays on the response pins until the requester raises its response ready. While an untaken response is waiting, that channel's request ready is low, so no new request can enter it. A waiting response stops only its own channel.

Top module: `vport_mapper`

## Requirements
- R1: After reset, every virtual port is unmapped and both mapping registers read 0xFF. Both request readys are high, both response valids are low, and no write strobe is active.
- R2: A virtual write to offset 0 (DIR) or offset 1 (OUT) of a mapped virtual port raises that register's strobe for the mapped physical port, carrying the write data. The strobe is active in the cycle the request is taken. The bank changes at the same clock edge.
- R3: A virtual read of offset 0 (DIR), 1 (OUT) or 2 (IN) of a mapped virtual port returns the mapped port's value for that register. The response is valid in the cycle after the request is taken. Virtual address bits [3:2] select the virtual port and bits [1:0] select the offset.
- R4: A mapping field value of 8 to 15 leaves its virtual port unmapped. Reads of an unmapped virtual port return 0, and writes to it change no port.
- R5: Offset 3 of every virtual port reads 0 and ignores writes. Writes to offset 2 (IN) are ignored on both paths.
- R6: Mapping register 0 sits at virtual address 16 and mapping register 1 at address 17. Both can be read and written. Address 16 holds virtual port 0 in bits [3:0] and virtual port 1 in bits [7:4]. Address 17 holds virtual port 2 in bits [3:0] and virtual port 3 in bits [7:4]. Addresses 18 to 31 read 0 and ignore writes.
- R7: A mapping write applies to the very next access, with no extra cycle.
- R8: A direct access at address {port[2:0], offset[1:0]} reads or writes that port's register, with the same offset meanings as the virtual window. The direct response is valid in the cycle after the request is taken.
- R9: When both paths write the same register of the same port in one cycle, the direct data lands. When they write different registers, both land.
- R10: While a response is valid and its response ready is low, the response data is held, that channel's request ready is low, and a request waiting on that channel has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_valid | input | 1 | Virtual-window request valid |
| v_ready | output | 1 | Virtual-window request ready |
| v_write | input | 1 | Virtual request is a write |
| v_addr | input | 5 | Virtual address (0-15 window, 16-17 mapping) |
| v_wdata | input | 8 | Virtual write data |
| v_rvalid | output | 1 | Virtual read response valid |
| v_rready | input | 1 | Virtual read response ready |
| v_rdata | output | 8 | Virtual read response data |
| d_valid | input | 1 | Direct request valid |
| d_ready | output | 1 | Direct request ready |
| d_write | input | 1 | Direct request is a write |
| d_addr | input | 5 | Direct address {port, offset} |
| d_wdata | input | 8 | Direct write data |
| d_rvalid | output | 1 | Direct read response valid |
| d_rready | input | 1 | Direct read response ready |
| d_rdata | output | 8 | Direct read response data |
| dir_we | output | 8 | Per-port DIR write strobe |
| dir_wd | output | 64 | Per-port DIR write data, port p at [8p+7:8p] |
| out_we | output | 8 | Per-port OUT write strobe |
| out_wd | output | 64 | Per-port OUT write data, port p at [8p+7:8p] |
| bank_dir | input | 64 | Current DIR value of each port |
| bank_out | input | 64 | Current OUT value of each port |
| bank_in | input | 64 | Current IN value of each port |

## Verification
Write strobes are combinational and appear in the cycle a request is taken. The bench's model banks therefore change at the same rising edge, and bank contents are compared at the falling edge that follows. Read responses are registered and due exactly one cycle after the request is taken. The bench drives each request at a falling edge and checks the response valid and data at the next falling edge. For a mapping change, the following request is issued in the very next cycle, so any added latency would send it to the old port. The back-pressure case holds response ready low for a full cycle. It then checks that the held data is unchanged and that the waiting write has not reached the bank. Only after releasing ready does it expect that write to land.

// File: rtl/vpm_pkg.sv
package vpm_pkg;
  // Kind of target selected by a virtual-window address
  typedef enum logic [1:0] {
    VK_ZERO = 2'd0,   // reads 0, writes dropped
    VK_PORT = 2'd1,   // forwarded to a physical port register
    VK_MAP  = 2'd2    // one of the mapping registers
  } vk_e;

  // Register offsets inside a port (window and direct path share them)
  localparam logic [1:0] RG_DIR  = 2'd0;
  localparam logic [1:0] RG_OUT  = 2'd1;
  localparam logic [1:0] RG_IN   = 2'd2;
  localparam logic [1:0] RG_FLAG = 2'd3;

  // Width of one mapping field
  localparam int FLD_W = 4;
endpackage

// File: rtl/vpm_map_regs.sv
module vpm_map_regs import vpm_pkg::*; #(
  parameter int DW   = 8,
  parameter int NVP  = 4,
  parameter int NMAP = 2,
  localparam int FPR  = DW / FLD_W,
  localparam int MI_W = (NMAP > 1) ? $clog2(NMAP) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [MI_W-1:0]             idx,
  input  logic [DW-1:0]               wdata,
  output logic [DW-1:0]               rdata,
  output logic [NVP-1:0][FLD_W-1:0]   fld
);
  logic [NMAP-1:0][DW-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '1;
    end else if (we) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = regs[idx];

  // Each virtual port takes its own nibble, low nibble first
  for (genvar v = 0; v < NVP; v++) begin : g_fld
    assign fld[v] = regs[v / FPR][(v % FPR) * FLD_W +: FLD_W];
  end

  // R6
  map_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(idx)] == $past(wdata));
endmodule

// File: rtl/vpm_vdecode.sv
module vpm_vdecode import vpm_pkg::*; #(
  parameter int NPORT   = 8,
  parameter int NVP     = 4,
  parameter int NMAP    = 2,
  localparam int PS_W    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VP_W    = (NVP > 1) ? $clog2(NVP) : 1,
  localparam int VADDR_W = VP_W + 3,
  localparam int MI_W    = (NMAP > 1) ? $clog2(NMAP) : 1
) (
  input  logic [VADDR_W-1:0]        addr,
  input  logic [NVP-1:0][FLD_W-1:0] fld,
  output vk_e                       kind,
  output logic [PS_W-1:0]           port,
  output logic [1:0]                rsel,
  output logic [MI_W-1:0]           midx
);
  logic [VP_W-1:0]      vp;
  logic [FLD_W-1:0]     sel_fld;
  logic [VADDR_W-2:0]   off;

  assign vp      = addr[VP_W+1:2];
  assign sel_fld = fld[vp];
  assign off     = addr[VADDR_W-2:0];
  assign rsel    = addr[1:0];

  always_comb begin
    kind = VK_ZERO;
    port = '0;
    midx = '0;
    if (!addr[VADDR_W-1]) begin
      // window: mapped port and a real register offset
      if ((int'(sel_fld) < NPORT) && (addr[1:0] != RG_FLAG)) begin
        kind = VK_PORT;
        port = sel_fld[PS_W-1:0];
      end
    end else if (int'(off) < NMAP) begin
      kind = VK_MAP;
      midx = off[MI_W-1:0];
    end
  end
endmodule

// File: rtl/vpm_wr_arb.sv
module vpm_wr_arb #(
  parameter int DW = 8
) (
  input  logic          v_hit,
  input  logic [DW-1:0] v_data,
  input  logic          d_hit,
  input  logic [DW-1:0] d_data,
  output logic          we,
  output logic [DW-1:0] wd
);
  // direct path has priority when both target the register
  assign we = v_hit | d_hit;
  assign wd = d_hit ? d_data : v_data;
endmodule

// File: rtl/vpm_rsp_slot.sv
module vpm_rsp_slot #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          req_ready
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (cap) begin
      rsp_valid <= 1'b1;
      rsp_data  <= cap_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R3
  rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(cap));
endmodule

// File: rtl/vport_mapper.sv
module vport_mapper import vpm_pkg::*; #(
  parameter int NPORT = 8,
  parameter int DW    = 8,
  parameter int NVP   = 4,
  localparam int PS_W    = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int VP_W    = (NVP > 1) ? $clog2(NVP) : 1,
  localparam int VADDR_W = VP_W + 3,
  localparam int DADDR_W = PS_W + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  v_valid,
  output logic                  v_ready,
  input  logic                  v_write,
  input  logic [VADDR_W-1:0]    v_addr,
  input  logic [DW-1:0]         v_wdata,
  output logic                  v_rvalid,
  input  logic                  v_rready,
  output logic [DW-1:0]         v_rdata,
  input  logic                  d_valid,
  output logic                  d_ready,
  input  logic                  d_write,
  input  logic [DADDR_W-1:0]    d_addr,
  input  logic [DW-1:0]         d_wdata,
  output logic                  d_rvalid,
  input  logic                  d_rready,
  output logic [DW-1:0]         d_rdata,
  output logic [NPORT-1:0]      dir_we,
  output logic [NPORT*DW-1:0]   dir_wd,
  output logic [NPORT-1:0]      out_we,
  output logic [NPORT*DW-1:0]   out_wd,
  input  logic [NPORT*DW-1:0]   bank_dir,
  input  logic [NPORT*DW-1:0]   bank_out,
  input  logic [NPORT*DW-1:0]   bank_in
);
  localparam int FPR  = DW / FLD_W;
  localparam int NMAP = (NVP + FPR - 1) / FPR;
  localparam int MI_W = (NMAP > 1) ? $clog2(NMAP) : 1;

  logic v_fire, d_fire;
  assign v_fire = v_valid && v_ready;
  assign d_fire = d_valid && d_ready;

  // ---------------- virtual path decode and mapping ----------------
  logic [NVP-1:0][FLD_W-1:0] fld;
  vk_e                       vkind;
  logic [PS_W-1:0]           vport;
  logic [1:0]                vreg;
  logic [MI_W-1:0]           vmidx;
  logic [DW-1:0]             map_rd;

  vpm_vdecode #(.NPORT(NPORT), .NVP(NVP), .NMAP(NMAP)) u_dec (
    .addr (v_addr),
    .fld  (fld),
    .kind (vkind),
    .port (vport),
    .rsel (vreg),
    .midx (vmidx)
  );

  vpm_map_regs #(.DW(DW), .NVP(NVP), .NMAP(NMAP)) u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (v_fire && v_write && (vkind == VK_MAP)),
    .idx   (vmidx),
    .wdata (v_wdata),
    .rdata (map_rd),
    .fld   (fld)
  );

  // ---------------- direct path decode ----------------
  logic [PS_W-1:0] dport;
  logic [1:0]      dreg;
  logic            d_ok;
  assign dport = d_addr[DADDR_W-1:2];
  assign dreg  = d_addr[1:0];
  assign d_ok  = int'(dport) < NPORT;

  logic v_port_wr, d_port_wr;
  assign v_port_wr = v_fire && v_write && (vkind == VK_PORT);
  assign d_port_wr = d_fire && d_write && d_ok;

  // ---------------- per-port write arbitration ----------------
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic v_dir_hit, d_dir_hit, v_out_hit, d_out_hit;
    assign v_dir_hit = v_port_wr && (int'(vport) == p) && (vreg == RG_DIR);
    assign v_out_hit = v_port_wr && (int'(vport) == p) && (vreg == RG_OUT);
    assign d_dir_hit = d_port_wr && (int'(dport) == p) && (dreg == RG_DIR);
    assign d_out_hit = d_port_wr && (int'(dport) == p) && (dreg == RG_OUT);

    vpm_wr_arb #(.DW(DW)) u_dir_arb (
      .v_hit  (v_dir_hit),
      .v_data (v_wdata),
      .d_hit  (d_dir_hit),
      .d_data (d_wdata),
      .we     (dir_we[p]),
      .wd     (dir_wd[p*DW +: DW])
    );

    vpm_wr_arb #(.DW(DW)) u_out_arb (
      .v_hit  (v_out_hit),
      .v_data (v_wdata),
      .d_hit  (d_out_hit),
      .d_data (d_wdata),
      .we     (out_we[p]),
      .wd     (out_wd[p*DW +: DW])
    );
  end

  // ---------------- read selection ----------------
  logic [DW-1:0] v_rd_cap, d_rd_cap;

  always_comb begin
    v_rd_cap = '0;
    unique case (vkind)
      VK_PORT: begin
        unique case (vreg)
          RG_DIR:  v_rd_cap = bank_dir[int'(vport)*DW +: DW];
          RG_OUT:  v_rd_cap = bank_out[int'(vport)*DW +: DW];
          RG_IN:   v_rd_cap = bank_in[int'(vport)*DW +: DW];
          default: v_rd_cap = '0;
        endcase
      end
      VK_MAP:  v_rd_cap = map_rd;
      default: v_rd_cap = '0;
    endcase
  end

  always_comb begin
    d_rd_cap = '0;
    if (d_ok) begin
      unique case (dreg)
        RG_DIR:  d_rd_cap = bank_dir[int'(dport)*DW +: DW];
        RG_OUT:  d_rd_cap = bank_out[int'(dport)*DW +: DW];
        RG_IN:   d_rd_cap = bank_in[int'(dport)*DW +: DW];
        default: d_rd_cap = '0;
      endcase
    end
  end

  // ---------------- response slots, one per channel ----------------
  vpm_rsp_slot #(.DW(DW)) u_vrsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (v_fire && !v_write),
    .cap_data  (v_rd_cap),
    .rsp_ready (v_rready),
    .rsp_valid (v_rvalid),
    .rsp_data  (v_rdata),
    .req_ready (v_ready)
  );

  vpm_rsp_slot #(.DW(DW)) u_drsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (d_fire && !d_write),
    .cap_data  (d_rd_cap),
    .rsp_ready (d_rready),
    .rsp_valid (d_rvalid),
    .rsp_data  (d_rdata),
    .req_ready (d_ready)
  );

  // ---------------- assertions ----------------
  // R4
  zero_target_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_fire && v_write && (vkind != VK_PORT) && !d_fire) |-> ((dir_we == '0) && (out_we == '0)));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_fire && d_fire) |-> ($onehot0(dir_we | out_we) || ($countones(dir_we | out_we) == 1)));

  // R9
  direct_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (d_fire && d_write && d_ok && (dreg == RG_DIR)) |->
      (dir_we[dport] && (dir_wd[int'(dport)*DW +: DW] == d_wdata)));

  // R5
  in_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_fire && v_write && (v_addr[VADDR_W-1] == 1'b0) && (v_addr[1] == 1'b1) && !d_fire)
      |-> ((dir_we == '0) && (out_we == '0)));
endmodule

// File: tb/sim_vport_mapper.sv
module sim_vport_mapper;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst_n;
  logic        v_valid, v_ready, v_write, v_rvalid, v_rready;
  logic [4:0]  v_addr;
  logic [7:0]  v_wdata, v_rdata;
  logic        d_valid, d_ready, d_write, d_rvalid, d_rready;
  logic [4:0]  d_addr;
  logic [7:0]  d_wdata, d_rdata;
  logic [7:0]  dir_we, out_we;
  logic [63:0] dir_wd, out_wd, bank_dir, bank_out, bank_in;

  vport_mapper u0 (
    .clk(clk), .rst_n(rst_n),
    .v_valid(v_valid), .v_ready(v_ready), .v_write(v_write), .v_addr(v_addr),
    .v_wdata(v_wdata), .v_rvalid(v_rvalid), .v_rready(v_rready), .v_rdata(v_rdata),
    .d_valid(d_valid), .d_ready(d_ready), .d_write(d_write), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_rvalid(d_rvalid), .d_rready(d_rready), .d_rdata(d_rdata),
    .dir_we(dir_we), .dir_wd(dir_wd), .out_we(out_we), .out_wd(out_wd),
    .bank_dir(bank_dir), .bank_out(bank_out), .bank_in(bank_in)
  );

  // Port banks driven by the block's strobes
  logic [7:0] rdir [8];
  logic [7:0] rout [8];
  logic [7:0] pins [8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 8; p++) begin rdir[p] <= 8'h00; rout[p] <= 8'h00; end
    end else begin
      for (int p = 0; p < 8; p++) begin
        if (dir_we[p]) rdir[p] <= dir_wd[p*8 +: 8];
        if (out_we[p]) rout[p] <= out_wd[p*8 +: 8];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < 8; p++) begin
      bank_dir[p*8 +: 8] = rdir[p];
      bank_out[p*8 +: 8] = rout[p];
      bank_in[p*8 +: 8]  = pins[p];
    end
  end

  // Reference model
  logic [7:0] mdir [8];
  logic [7:0] mout [8];
  logic [7:0] mmap [2];

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] mfield(input int vp);
    return (vp % 2 == 0) ? mmap[vp/2][3:0] : mmap[vp/2][7:4];
  endfunction

  function automatic logic [7:0] model_vread(input logic [4:0] a);
    logic [3:0] f;
    if (a[4]) return (a[3:0] < 2) ? mmap[a[0]] : 8'h00;
    f = mfield(int'(a[3:2]));
    if (f >= 8 || a[1:0] == 2'd3) return 8'h00;
    case (a[1:0])
      2'd0: return mdir[f[2:0]];
      2'd1: return mout[f[2:0]];
      default: return pins[f[2:0]];
    endcase
  endfunction

  function automatic logic [7:0] model_dread(input logic [4:0] a);
    case (a[1:0])
      2'd0: return mdir[a[4:2]];
      2'd1: return mout[a[4:2]];
      2'd2: return pins[a[4:2]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_vwrite(input logic [4:0] a, input logic [7:0] d);
    logic [3:0] f;
    if (a[4]) begin
      if (a[3:0] < 2) mmap[a[0]] = d;
    end else begin
      f = mfield(int'(a[3:2]));
      if (f < 8) begin
        if (a[1:0] == 2'd0) mdir[f[2:0]] = d;
        if (a[1:0] == 2'd1) mout[f[2:0]] = d;
      end
    end
  endtask

  task automatic model_dwrite(input logic [4:0] a, input logic [7:0] d);
    if (a[1:0] == 2'd0) mdir[a[4:2]] = d;
    if (a[1:0] == 2'd1) mout[a[4:2]] = d;
  endtask

  task automatic banks_match(input string req);
    bit ok = 1'b1;
    for (int p = 0; p < 8; p++)
      if (rdir[p] !== mdir[p] || rout[p] !== mout[p]) ok = 1'b0;
    chk(ok, req, "bank contents", {rdir[0], rdir[1], rdir[2], rdir[3], rout[0], rout[1], rout[2], rout[3]},
        {mdir[0], mdir[1], mdir[2], mdir[3], mout[0], mout[1], mout[2], mout[3]});
  endtask

  // One cycle on both channels; called at a falling edge with readys high
  task automatic op(input bit vv, input bit vw, input logic [4:0] va, input logic [7:0] vd,
                    input bit dv, input bit dw, input logic [4:0] da, input logic [7:0] dd,
                    input string req);
    logic [7:0] ev, ed;
    ev = model_vread(va);
    ed = model_dread(da);
    v_valid = vv; v_write = vw; v_addr = va; v_wdata = vd;
    d_valid = dv; d_write = dw; d_addr = da; d_wdata = dd;
    @(negedge clk);
    v_valid = 1'b0; d_valid = 1'b0;
    if (vv && !vw) chk(v_rvalid === 1'b1 && v_rdata === ev, req, "virtual read", {v_rvalid, v_rdata}, {1'b1, ev});
    if (dv && !dw) chk(d_rvalid === 1'b1 && d_rdata === ed, req, "direct read", {d_rvalid, d_rdata}, {1'b1, ed});
    if (vv && vw) model_vwrite(va, vd);
    if (dv && dw) model_dwrite(da, dd);
    if (vw || dw) banks_match(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1a2b);
    rst_n = 1'b0;
    v_valid = 0; v_write = 0; v_addr = 0; v_wdata = 0; v_rready = 1;
    d_valid = 0; d_write = 0; d_addr = 0; d_wdata = 0; d_rready = 1;
    for (int p = 0; p < 8; p++) begin
      pins[p] = 8'h30 + 8'(p); mdir[p] = 0; mout[p] = 0;
    end
    mmap[0] = 8'hFF; mmap[1] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(v_ready && d_ready && !v_rvalid && !d_rvalid, "R1", "handshake at reset",
        {v_ready, d_ready, v_rvalid, d_rvalid}, 4'b1100);
    chk(dir_we == 0 && out_we == 0, "R1", "strobes at reset", {dir_we, out_we}, 0);
    op(1, 0, 5'd16, 0, 0, 0, 0, 0, "R1");
    op(1, 0, 5'd17, 0, 0, 0, 0, 0, "R1");

    // R4 unmapped window
    op(1, 0, 5'd4, 0, 0, 0, 0, 0, "R4");
    op(1, 1, 5'd0, 8'h77, 0, 0, 0, 0, "R4");

    // R6 / R2 / R3: vp0 -> port 3, vp1 -> port 5
    op(1, 1, 5'd16, 8'h53, 0, 0, 0, 0, "R6");
    op(1, 1, 5'd0, 8'hA5, 0, 0, 0, 0, "R2");
    op(1, 1, 5'd5, 8'h3C, 0, 0, 0, 0, "R2");
    op(1, 0, 5'd0, 0, 0, 0, 0, 0, "R3");
    op(1, 0, 5'd5, 0, 0, 0, 0, 0, "R3");
    op(1, 0, 5'd6, 0, 0, 0, 0, 0, "R3");
    op(1, 0, 5'd16, 0, 0, 0, 0, 0, "R6");
    op(1, 0, 5'd18, 0, 0, 0, 0, 0, "R6");
    op(1, 1, 5'd25, 8'h12, 0, 0, 0, 0, "R6");
    op(1, 0, 5'd16, 0, 0, 0, 0, 0, "R6");

    // R5 flag offset and IN writes
    op(1, 0, 5'd3, 0, 0, 0, 0, 0, "R5");
    op(1, 1, 5'd3, 8'hEE, 0, 0, 0, 0, "R5");
    op(1, 1, 5'd2, 8'hDD, 0, 0, 0, 0, "R5");
    op(0, 0, 0, 0, 1, 1, {3'd3, 2'd2}, 8'hCC, "R5");

    // R7 mapping change applies on the next access
    op(1, 1, 5'd16, 8'h51, 0, 0, 0, 0, "R7");
    op(1, 1, 5'd1, 8'h9B, 0, 0, 0, 0, "R7");
    op(1, 0, 5'd1, 0, 0, 0, 0, 0, "R7");

    // R4 field values 8..15
    op(1, 1, 5'd17, 8'h9F, 0, 0, 0, 0, "R4");
    op(1, 1, 5'd8, 8'h44, 0, 0, 0, 0, "R4");
    op(1, 0, 5'd13, 0, 0, 0, 0, 0, "R4");

    // R8 direct path
    op(0, 0, 0, 0, 1, 1, {3'd6, 2'd1}, 8'h6E, "R8");
    op(0, 0, 0, 0, 1, 0, {3'd6, 2'd1}, 0, "R8");
    op(0, 0, 0, 0, 1, 0, {3'd6, 2'd3}, 0, "R8");

    // R9 collisions (vp0 -> port 1)
    op(1, 1, 5'd0, 8'h11, 1, 1, {3'd1, 2'd0}, 8'h22, "R9");
    op(1, 1, 5'd1, 8'h33, 1, 1, {3'd1, 2'd0}, 8'h44, "R9");

    // R10 back-pressure on the virtual channel
    v_rready = 1'b0;
    v_valid = 1; v_write = 0; v_addr = 5'd1;
    @(negedge clk);
    chk(v_rvalid && !v_ready && v_rdata == mout[1], "R10", "response held, ready low",
        {v_rvalid, v_ready, v_rdata}, {2'b10, mout[1]});
    v_write = 1; v_addr = 5'd0; v_wdata = 8'h5A;
    @(negedge clk);
    chk(v_rvalid && v_rdata == mout[1] && rdir[1] == mdir[1], "R10", "stall keeps data and bank",
        {v_rvalid, v_rdata, rdir[1]}, {1'b1, mout[1], mdir[1]});
    v_rready = 1'b1;
    @(negedge clk);
    v_valid = 0;
    model_vwrite(5'd0, 8'h5A);
    chk(!v_rvalid, "R10", "response drained", v_rvalid, 0);
    banks_match("R10");

    // Random mix
    for (int i = 0; i < 500; i++) begin
      logic [4:0] ra, rd;
      if ($urandom % 8 == 0) pins[$urandom % 8] = 8'($urandom);
      ra = 5'($urandom);
      rd = 5'($urandom);
      op(($urandom % 4) != 0, $urandom % 2 == 1, ra, 8'($urandom),
         ($urandom % 3) == 0, $urandom % 2 == 1, rd, 8'($urandom), "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule